// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block decides where a 32-bit core with 4-byte instructions fetches next. It holds the program counter and, for the instruction being retired, picks one of several candidates. The candidates are the sequential address, an absolute target inside the current 256 MB region, a PC-relative branch target taken always or on a register comparison, a register-indirect target, and the three saved return addresses. The decoder supplies a flow-kind code, a condition selector, both immediates, operands A and B, the saved ea/ba/ra values and the destination index C.

Besides the next PC, the unit produces the link value PC+4 with two write strobes. One writes the return-address register for both call kinds. The other writes register C for the next-PC-read instruction. A third strobe tells the control-register block to copy the saved exception status into the live status on exception return. The PC updates only on cycles where `advance` is high. Everything else is combinational from the current PC and the decoded fields.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-low reset loads `pc_q` with parameter RESET_VEC (default 0x00000100). While `advance` is low, `pc_q` holds its value.
- R2: Flow kinds are encoded as follows: 0 sequential, 1 absolute jump, 2 call, 3 unconditional branch, 4 conditional branch, 5 register jump, 6 register call, 7 subroutine return, 8 breakpoint return, 9 exception return, 10 read-next-PC. Codes 11 to 15 act as sequential. Sequential and read-next-PC give `next_pc` = PC+4, wrapping modulo 2^32.
- R3: Absolute jump and call give `next_pc` = {PC[31:28], imm26, 2'b00}.
- R4: Unconditional branch, and conditional branch when taken, give `next_pc` = PC + 4 + (sign-extended imm16 with bits 1:0 forced to zero).
- R5: The `cond_sel` encoding compares operand A against operand B: 0 equal, 1 not equal, 2 signed greater-or-equal, 3 signed less-than, 4 unsigned greater-or-equal, 5 unsigned less-than. Values 6 and 7 are never taken. A conditional branch that is not taken gives PC+4.
- R6: Register jump and register call give `next_pc` = operand A. Call and register call raise `ra_we` with `link_val` = PC+4.
- R7: Subroutine return takes `next_pc` from `reg_ra`, breakpoint return from `reg_ba` and exception return from `reg_ea`. Only exception return raises `status_restore`.
- R8: Read-next-PC raises `c_we` with `link_val` = PC+4 only when `dest_c` is not 0. It does not change the flow of the PC.
- R9: `redirect` is high for every kind that transfers control (kinds 1-3 and 5-9) and for a taken conditional branch. This includes a branch whose target equals PC+4. It is low otherwise.
- R10: `redirect`, `ra_we`, `c_we` and `status_restore` are all low while `advance` is low. At most one of the three write strobes is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Retire the presented instruction and update the PC |
| flow_kind | input | 4 | Control-flow kind code (R2) |
| cond_sel | input | 3 | Branch condition selector (R5) |
| imm16 | input | 16 | Branch displacement field |
| imm26 | input | 26 | Absolute jump word index |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| reg_ea | input | 32 | Saved exception return address |
| reg_ba | input | 32 | Saved breakpoint return address |
| reg_ra | input | 32 | Subroutine return address |
| dest_c | input | 5 | Destination register index C |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Selected next program counter |
| redirect | output | 1 | Control leaves the sequential path |
| link_val | output | 32 | PC+4 for link writes |
| ra_we | output | 1 | Write link_val into the return-address register |
| c_we | output | 1 | Write link_val into register C |
| status_restore | output | 1 | Copy saved exception status into status |

## Verification
The hardest cases to reach are the sign and region edges. These are a condition whose signed and unsigned verdicts disagree, a backward branch with a negative displacement, a PC at the top of memory wrapping on increment, and a displacement with low bits set that must collapse to PC+4 while still counting as a redirect. The stimulus first loads an arbitrary PC through a register jump. It then sweeps all eight condition codes against every ordered pair of operands drawn from zero, one, the largest positive value, the most negative value and all-ones. Displacements are chosen at 0x7FFF, 0x8000, 0xFFFF and 0x0003.

// File: rtl/npc_pkg.sv
// Package: shared encodings for the next-PC unit.
// Assumes the decoder drives these codes directly on the flow_kind and
// cond_sel ports.
package npc_pkg;

    typedef enum logic [3:0] {
        FK_SEQ    = 4'd0,
        FK_JABS   = 4'd1,
        FK_CALL   = 4'd2,
        FK_BR     = 4'd3,
        FK_BCOND  = 4'd4,
        FK_JREG   = 4'd5,
        FK_CALLR  = 4'd6,
        FK_RET    = 4'd7,
        FK_BRET   = 4'd8,
        FK_ERET   = 4'd9,
        FK_NEXTPC = 4'd10
    } flow_kind_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_GE  = 3'd2,
        CC_LT  = 3'd3,
        CC_GEU = 3'd4,
        CC_LTU = 3'd5
    } cond_e;

endpackage

// File: rtl/npc_cond_eval.sv
// Module: npc_cond_eval
// Evaluates a branch condition on two register operands, comparing A
// against B. Assumes two's complement operands. Selectors outside the
// defined set evaluate false.
module npc_cond_eval #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   sel,
    output logic         take
);
    import npc_pkg::*;

    logic eq_w;
    logic lts_w;
    logic ltu_w;

    // Purpose: form the three primitive relations once.
    always_comb begin
        eq_w  = (opa == opb);
        lts_w = ($signed(opa) < $signed(opb));
        ltu_w = (opa < opb);
    end

    // Purpose: map the selector onto the primitive relations.
    always_comb begin
        case (sel)
            CC_EQ:   take = eq_w;
            CC_NE:   take = !eq_w;
            CC_GE:   take = !lts_w;
            CC_LT:   take = lts_w;
            CC_GEU:  take = !ltu_w;
            CC_LTU:  take = ltu_w;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
// Module: npc_target_gen
// Forms the PC-derived candidate addresses: sequential, absolute within
// the current region, and PC-relative branch. Assumes the word size is
// 4 bytes. The region is whatever upper PC bits the absolute field does
// not cover.
module npc_target_gen #(
    parameter int W     = 32,
    parameter int IMM_J = 26,
    parameter int IMM_B = 16
) (
    input  logic [W-1:0]     pc,
    input  logic [IMM_J-1:0] imm_j,
    input  logic [IMM_B-1:0] imm_b,
    output logic [W-1:0]     seq_tgt,
    output logic [W-1:0]     abs_tgt,
    output logic [W-1:0]     rel_tgt
);
    localparam int REGION_BITS = W - IMM_J - 2;
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] disp_w;

    // Purpose: sign-extend the displacement and clear its two low bits.
    always_comb begin
        disp_w = {{(W-IMM_B){imm_b[IMM_B-1]}}, imm_b[IMM_B-1:2], 2'b00};
    end

    // Purpose: sequential and relative adders.
    always_comb begin
        seq_tgt = pc + STEP;
        rel_tgt = pc + STEP + disp_w;
    end

    // Purpose: absolute target; region bits exist only if the field leaves room.
    generate
        if (REGION_BITS > 0) begin : g_region
            always_comb abs_tgt = {pc[W-1 -: REGION_BITS], imm_j, 2'b00};
        end else begin : g_flat
            always_comb abs_tgt = W'({imm_j, 2'b00});
        end
    endgenerate

endmodule

// File: rtl/npc_select.sv
// Module: npc_select
// Chooses the next PC from the candidates by flow kind, and raises the
// redirect and write strobes. Assumes unknown kinds behave as sequential.
// Every strobe is qualified by advance.
module npc_select #(
    parameter int W     = 32,
    parameter int IDX_W = 5
) (
    input  logic             advance,
    input  logic [3:0]       kind,
    input  logic             take,
    input  logic [IDX_W-1:0] dest_c,
    input  logic [W-1:0]     seq_tgt,
    input  logic [W-1:0]     abs_tgt,
    input  logic [W-1:0]     rel_tgt,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     sv_ea,
    input  logic [W-1:0]     sv_ba,
    input  logic [W-1:0]     sv_ra,
    output logic [W-1:0]     next_pc,
    output logic             redirect,
    output logic             ra_we,
    output logic             c_we,
    output logic             status_restore
);
    import npc_pkg::*;

    logic xfer_w;
    logic ra_w;
    logic c_w;
    logic st_w;

    // Purpose: target mux and raw (unqualified) side effects per kind.
    always_comb begin
        next_pc = seq_tgt;
        xfer_w  = 1'b0;
        ra_w    = 1'b0;
        c_w     = 1'b0;
        st_w    = 1'b0;
        case (kind)
            FK_JABS:  begin next_pc = abs_tgt; xfer_w = 1'b1; end
            FK_CALL:  begin next_pc = abs_tgt; xfer_w = 1'b1; ra_w = 1'b1; end
            FK_BR:    begin next_pc = rel_tgt; xfer_w = 1'b1; end
            FK_BCOND: begin
                if (take) begin
                    next_pc = rel_tgt;
                    xfer_w  = 1'b1;
                end
            end
            FK_JREG:  begin next_pc = opa;   xfer_w = 1'b1; end
            FK_CALLR: begin next_pc = opa;   xfer_w = 1'b1; ra_w = 1'b1; end
            FK_RET:   begin next_pc = sv_ra; xfer_w = 1'b1; end
            FK_BRET:  begin next_pc = sv_ba; xfer_w = 1'b1; end
            FK_ERET:  begin next_pc = sv_ea; xfer_w = 1'b1; st_w = 1'b1; end
            FK_NEXTPC: c_w = (dest_c != '0);
            default:  ;
        endcase
    end

    // Purpose: qualify every strobe with advance.
    always_comb begin
        redirect       = advance && xfer_w;
        ra_we          = advance && ra_w;
        c_we           = advance && c_w;
        status_restore = advance && st_w;
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit
// Top of the next-PC unit: holds the PC register and wires the condition
// evaluator, the target generator and the selector. Assumes one
// instruction is presented per cycle and is retired when advance is high.
module npc_unit #(
    parameter int          W         = 32,
    parameter int          IMM_J     = 26,
    parameter int          IMM_B     = 16,
    parameter int          IDX_W     = 5,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [3:0]       flow_kind,
    input  logic [2:0]       cond_sel,
    input  logic [IMM_B-1:0] imm16,
    input  logic [IMM_J-1:0] imm26,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [W-1:0]     reg_ea,
    input  logic [W-1:0]     reg_ba,
    input  logic [W-1:0]     reg_ra,
    input  logic [IDX_W-1:0] dest_c,
    output logic [W-1:0]     pc_q,
    output logic [W-1:0]     next_pc,
    output logic             redirect,
    output logic [W-1:0]     link_val,
    output logic             ra_we,
    output logic             c_we,
    output logic             status_restore
);
    import npc_pkg::*;

    localparam int RB = W - IMM_J - 2;
    localparam logic [W-1:0] RST_PC = W'(RESET_VEC);

    logic         take_w;
    logic [W-1:0] seq_w;
    logic [W-1:0] abs_w;
    logic [W-1:0] rel_w;

    npc_cond_eval #(.W(W)) u_cond (
        .opa  (opnd_a),
        .opb  (opnd_b),
        .sel  (cond_sel),
        .take (take_w)
    );

    npc_target_gen #(.W(W), .IMM_J(IMM_J), .IMM_B(IMM_B)) u_tgt (
        .pc      (pc_q),
        .imm_j   (imm26),
        .imm_b   (imm16),
        .seq_tgt (seq_w),
        .abs_tgt (abs_w),
        .rel_tgt (rel_w)
    );

    npc_select #(.W(W), .IDX_W(IDX_W)) u_sel (
        .advance        (advance),
        .kind           (flow_kind),
        .take           (take_w),
        .dest_c         (dest_c),
        .seq_tgt        (seq_w),
        .abs_tgt        (abs_w),
        .rel_tgt        (rel_w),
        .opa            (opnd_a),
        .sv_ea          (reg_ea),
        .sv_ba          (reg_ba),
        .sv_ra          (reg_ra),
        .next_pc        (next_pc),
        .redirect       (redirect),
        .ra_we          (ra_we),
        .c_we           (c_we),
        .status_restore (status_restore)
    );

    // Purpose: the link value is always the sequential address.
    always_comb link_val = seq_w;

    // Purpose: PC register with reset vector and advance enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RST_PC;
        end else if (advance) begin
            pc_q <= next_pc;
        end
    end

    AST_RESET_LOAD: assert property (@(posedge clk) !rst_n |=> pc_q == RST_PC); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !advance |=> $stable(pc_q)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n) (advance && !redirect) |=> pc_q == $past(pc_q) + W'(4)); // R2
    AST_JABS_REGION: assert property (@(posedge clk) disable iff (!rst_n) (advance && flow_kind == FK_JABS) |=> pc_q[W-1 -: RB] == $past(pc_q[W-1 -: RB])); // R3
    AST_NOTTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (advance && flow_kind == FK_BCOND && !take_w) |-> !redirect); // R5
    AST_RET_FROM_RA: assert property (@(posedge clk) disable iff (!rst_n) (advance && flow_kind == FK_RET) |=> pc_q == $past(reg_ra)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !advance |-> !(redirect || ra_we || c_we || status_restore)); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ra_we, c_we, status_restore})); // R10

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    localparam logic [31:0] RVEC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [3:0]  flow_kind = 4'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic [15:0] imm16 = 16'd0;
    logic [25:0] imm26 = 26'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [31:0] reg_ea = 32'h1111_0000;
    logic [31:0] reg_ba = 32'h2222_0004;
    logic [31:0] reg_ra = 32'h3333_0008;
    logic [4:0]  dest_c = 5'd0;
    logic [31:0] pc_q, next_pc, link_val;
    logic        redirect, ra_we, c_we, status_restore;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_pc;

    always #2 clk = ~clk;

    npc_unit #(.RESET_VEC(RVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .advance(advance), .flow_kind(flow_kind),
        .cond_sel(cond_sel), .imm16(imm16), .imm26(imm26), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .reg_ea(reg_ea), .reg_ba(reg_ba), .reg_ra(reg_ra),
        .dest_c(dest_c), .pc_q(pc_q), .next_pc(next_pc), .redirect(redirect),
        .link_val(link_val), .ra_we(ra_we), .c_we(c_we),
        .status_restore(status_restore)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic cond_true(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) >= $signed(b);
            3'd3: return $signed(a) < $signed(b);
            3'd4: return a >= b;
            3'd5: return a < b;
            default: return 1'b0;
        endcase
    endfunction

    // Apply the current inputs for one cycle and check every output.
    task automatic apply(input string req, input logic adv);
        logic [31:0] seq, disp, e_next;
        logic e_xfer, e_ra, e_c, e_st;
        advance = adv;
        seq  = model_pc + 32'd4;
        disp = {{16{imm16[15]}}, imm16} & 32'hFFFF_FFFC;
        e_next = seq; e_xfer = 1'b0; e_ra = 1'b0; e_c = 1'b0; e_st = 1'b0;
        case (flow_kind)
            4'd1: begin e_next = {model_pc[31:28], imm26, 2'b00}; e_xfer = 1'b1; end
            4'd2: begin e_next = {model_pc[31:28], imm26, 2'b00}; e_xfer = 1'b1; e_ra = 1'b1; end
            4'd3: begin e_next = seq + disp; e_xfer = 1'b1; end
            4'd4: if (cond_true(cond_sel, opnd_a, opnd_b)) begin e_next = seq + disp; e_xfer = 1'b1; end
            4'd5: begin e_next = opnd_a; e_xfer = 1'b1; end
            4'd6: begin e_next = opnd_a; e_xfer = 1'b1; e_ra = 1'b1; end
            4'd7: begin e_next = reg_ra; e_xfer = 1'b1; end
            4'd8: begin e_next = reg_ba; e_xfer = 1'b1; end
            4'd9: begin e_next = reg_ea; e_xfer = 1'b1; e_st = 1'b1; end
            4'd10: e_c = (dest_c != 5'd0);
            default: ;
        endcase
        #1;
        chk({req, " next_pc"}, next_pc, e_next);
        chk({req, " redirect R9"}, {31'd0, redirect}, {31'd0, adv & e_xfer});
        chk({req, " ra_we R6"}, {31'd0, ra_we}, {31'd0, adv & e_ra});
        chk({req, " c_we R8"}, {31'd0, c_we}, {31'd0, adv & e_c});
        chk({req, " status_restore R7"}, {31'd0, status_restore}, {31'd0, adv & e_st});
        if (adv && (e_ra || e_c)) chk({req, " link_val"}, link_val, seq);
        @(posedge clk);
        #1;
        if (adv) model_pc = e_next;
        chk({req, " pc_q"}, pc_q, model_pc);
        advance = 1'b0;
    endtask

    task automatic set_pc(input logic [31:0] v);
        flow_kind = 4'd5; opnd_a = v;
        apply("R6 load", 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] vals [5];
        vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_pc = RVEC;
        chk("R1 reset pc", pc_q, RVEC);
        chk("R10 idle redirect", {31'd0, redirect}, 32'd0);

        // R1 / R10: a jump presented without advance does nothing
        flow_kind = 4'd2; imm26 = 26'h155_5555;
        apply("R1 hold", 1'b0);
        flow_kind = 4'd9;
        apply("R10 idle eret", 1'b0);

        // R2: sequential, wrap, unknown codes
        flow_kind = 4'd0;
        apply("R2 seq", 1'b1);
        set_pc(32'hFFFF_FFFC);
        flow_kind = 4'd0;
        apply("R2 wrap", 1'b1);
        for (int k = 11; k < 16; k++) begin
            flow_kind = 4'(k);
            apply("R2 unknown", 1'b1);
        end

        // R3: absolute jump and call keep region bits
        foreach (vals[i]) begin
            set_pc(32'hA123_4560);
            flow_kind = 4'd1; imm26 = vals[i][25:0];
            apply("R3 jabs", 1'b1);
            set_pc(32'h5000_0010);
            flow_kind = 4'd2; imm26 = ~vals[i][25:0];
            apply("R3 call", 1'b1);
        end

        // R4: relative branch displacements
        begin
            logic [15:0] ds [6];
            ds[0] = 16'h0000; ds[1] = 16'h7FFF; ds[2] = 16'h8000;
            ds[3] = 16'hFFFF; ds[4] = 16'h0003; ds[5] = 16'hFFFC;
            foreach (ds[i]) begin
                set_pc(32'h0040_0000);
                flow_kind = 4'd3; imm16 = ds[i];
                apply("R4 br", 1'b1);
            end
        end

        // R5: all selectors over all operand pairs
        for (int c = 0; c < 8; c++) begin
            foreach (vals[i]) begin
                foreach (vals[j]) begin
                    set_pc(32'h0000_8000);
                    flow_kind = 4'd4; cond_sel = 3'(c); imm16 = 16'hFFF0;
                    opnd_a = vals[i]; opnd_b = vals[j];
                    apply("R5 bcond", 1'b1);
                end
            end
        end

        // R6: register jump and call
        set_pc(32'h0000_2000);
        flow_kind = 4'd6; opnd_a = 32'hDEAD_BEE0;
        apply("R6 callr", 1'b1);

        // R7: returns
        flow_kind = 4'd7; apply("R7 ret", 1'b1);
        flow_kind = 4'd8; apply("R7 bret", 1'b1);
        flow_kind = 4'd9; apply("R7 eret", 1'b1);

        // R8: read-next-PC with zero and non-zero destination
        flow_kind = 4'd10; dest_c = 5'd0;
        apply("R8 nextpc c0", 1'b1);
        dest_c = 5'd7;
        apply("R8 nextpc c7", 1'b1);
        dest_c = 5'd31;
        apply("R8 nextpc idle", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule